// File: doc/BRIEF.md
# T1 Serial Framing Interface

This block connects a raw 1.544 Mb/s T1 bit stream to an external inverse-multiplexing device. It does not use a channelized backplane. Both bit clocks come from outside the system clock domain. Each one is brought into the system clock domain through a synchronizer, and the matching data travels through the same synchronizer, so clock and data stay aligned.

On the transmit path, serial data is sampled on the falling edge of the transmit bit clock. The block gathers 193 consecutive bits into a parallel frame word. The first bit received lands in the most significant position. The frame word is handed out with a one-cycle valid flag.

On the receive path, line data is re-timed to the rising edge of the receive bit clock and sent out serially. A framing pulse goes with it, high only while the framing bit (bit 0 of the frame) is on the output. Frame alignment comes from an external frame-start strobe, not from a framing search. Clearing the mode-enable input returns the interface to a quiet state.

Top module: `t1_serial_framer`

## Requirements
- R1: After reset, rx_ser_o, rx_fp_o and frame_vld_o are 0 and frame_o is all zeros.
- R2: While enabled, each transmit bit is the value of tx_data_i at a falling edge of tx_bclk_i. A rising edge of tx_bclk_i samples nothing.
- R3: In frame_o, the first bit received after the frame boundary sits at bit 192 and the 193rd at bit 0. frame_o keeps its value until the next frame is complete.
- R4: frame_vld_o is high for exactly one system clock after every 193rd sampled transmit bit, and is low at all other times.
- R5: While enabled, rx_ser_o takes the value of rx_data_i at each rising edge of rx_bclk_i and holds it until the next rising edge. Data changes between edges have no effect.
- R6: rx_fp_o is high while the emitted bit is at frame position 0. The position counts 0 to 192 on rising edges of rx_bclk_i and wraps from 192 back to 0 without a strobe.
- R7: A high rx_fs_i at a rising edge of rx_bclk_i makes that bit position 0, so rx_fp_o rises with it, even in the middle of a frame.
- R8: While mode_en_i is low:
  - rx_ser_o and rx_fp_o are held at 0 and frame_vld_o stays low.
  - A partly gathered transmit frame is discarded.
  - After re-enable, the first receive bit and the first transmit bit are both treated as position 0.
- R9: Outputs follow a bit clock edge within SYNC_STAGES+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_en_i | input | 1 | Serial framing mode enable, synchronous to clk_i |
| tx_bclk_i | input | 1 | 1.544 MHz transmit bit clock |
| tx_data_i | input | 1 | Transmit serial data, sampled on tx_bclk_i falling edge |
| rx_bclk_i | input | 1 | Receive line bit clock |
| rx_data_i | input | 1 | Receive line data |
| rx_fs_i | input | 1 | Receive frame-start strobe, sampled with rx_data_i |
| rx_ser_o | output | 1 | Re-timed receive serial data |
| rx_fp_o | output | 1 | Framing pulse, high during the framing bit |
| frame_o | output | 193 | Last complete transmit frame, first bit at MSB |
| frame_vld_o | output | 1 | One-cycle flag marking a new frame_o |

## Verification
The hardest case to reach is the edge choice on both paths. If the transmit data is set up long before both clock edges, a design that samples on the wrong edge looks correct.

The stimulus therefore changes tx_data_i only after the rising transmit edge. It also overwrites rx_data_i with its complement just after each rising receive edge. An implementation that samples on the wrong edge then captures the wrong bit.

Mid-frame strobes and an enable gap in the middle of a frame exercise realignment and the discarding of a partial frame.

// File: rtl/t1sf_pkg.sv
package t1sf_pkg;
  localparam int unsigned CHAN_NUM   = 24;
  localparam int unsigned CHAN_BITS  = 8;
  localparam int unsigned FRAME_BITS = 1 + CHAN_NUM * CHAN_BITS;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/t1sf_sync.sv
module t1sf_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[0] <= '0;
        else         stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/t1sf_edge_det.sv
module t1sf_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  if (RISING) begin : g_rise
    assign edge_o = sig_i & ~prev_q;
  end else begin : g_fall
    assign edge_o = ~sig_i & prev_q;
  end
endmodule

// File: rtl/t1sf_tx_collect.sv
module t1sf_tx_collect #(
  parameter int unsigned FRAME_BITS = 193,
  localparam int unsigned PW = $clog2(FRAME_BITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  smp_i,
  input  logic                  bit_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  vld_o
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [PW-1:0]         cnt_q;
  logic [FRAME_BITS-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      frame_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (smp_i) begin
        sh_q <= {sh_q[FRAME_BITS-3:0], bit_i};
        if (cnt_q == LAST) begin
          frame_o <= {sh_q, bit_i};
          vld_o   <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R4
  vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

  // R8
  vld_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(en_i));

  // R3
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_o) |-> vld_o);
endmodule

// File: rtl/t1sf_rx_emit.sv
module t1sf_rx_emit #(
  parameter int unsigned FRAME_BITS = 193,
  localparam int unsigned PW = $clog2(FRAME_BITS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_i,
  input  logic bit_i,
  input  logic fs_i,
  output logic ser_o,
  output logic fp_o
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [PW-1:0] pos_q, pos_nxt;
  logic          ser_q, fp_q;

  always_comb begin
    if (fs_i || pos_q == LAST) pos_nxt = '0;
    else                       pos_nxt = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= LAST;
      ser_q <= 1'b0;
      fp_q  <= 1'b0;
    end else if (!en_i) begin
      pos_q <= LAST;  // next enabled bit is the framing bit
      ser_q <= 1'b0;
      fp_q  <= 1'b0;
    end else if (edge_i) begin
      pos_q <= pos_nxt;
      ser_q <= bit_i;
      fp_q  <= (pos_nxt == '0);
    end
  end

  assign ser_o = ser_q & en_i;
  assign fp_o  = fp_q & en_i;

  // R7
  fs_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && fs_i && en_i) |=> (fp_o || !en_i));

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && en_i && !fs_i && pos_q == LAST) |=> (fp_o || !en_i));

  // R5
  ser_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(edge_i) && $past(en_i) && en_i) |-> $stable(ser_o));
endmodule

// File: rtl/t1_serial_framer.sv
module t1_serial_framer
  import t1sf_pkg::*;
#(
  parameter int unsigned FRAME_LEN   = FRAME_BITS,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_en_i,
  input  logic                 tx_bclk_i,
  input  logic                 tx_data_i,
  input  logic                 rx_bclk_i,
  input  logic                 rx_data_i,
  input  logic                 rx_fs_i,
  output logic                 rx_ser_o,
  output logic                 rx_fp_o,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic                 frame_vld_o
);
  localparam int unsigned NSYNC = 5;

  logic [NSYNC-1:0] raw, syn;
  logic             tx_fall, rx_rise;

  // clocks and data share one pipeline so their alignment survives
  assign raw = {tx_bclk_i, tx_data_i, rx_bclk_i, rx_data_i, rx_fs_i};

  t1sf_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  t1sf_edge_det #(.RISING(1'b0)) i_tx_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (syn[4]),
    .edge_o(tx_fall)
  );

  t1sf_edge_det #(.RISING(1'b1)) i_rx_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (syn[2]),
    .edge_o(rx_rise)
  );

  t1sf_tx_collect #(.FRAME_BITS(FRAME_LEN)) i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode_en_i),
    .smp_i  (tx_fall),
    .bit_i  (syn[3]),
    .frame_o(frame_o),
    .vld_o  (frame_vld_o)
  );

  t1sf_rx_emit #(.FRAME_BITS(FRAME_LEN)) i_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (mode_en_i),
    .edge_i(rx_rise),
    .bit_i (syn[1]),
    .fs_i  (syn[0]),
    .ser_o (rx_ser_o),
    .fp_o  (rx_fp_o)
  );

  // R8
  quiet_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_en_i && !$past(mode_en_i)) |-> !frame_vld_o);
endmodule

// File: tb/test_t1_serial_framer.sv
`timescale 1ns/1ps
module test_t1_serial_framer;
  localparam int FB = 193;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_en = 1'b0;
  logic          tx_bclk = 1'b0, tx_data = 1'b0;
  logic          rx_bclk = 1'b0, rx_data = 1'b0, rx_fs = 1'b0;
  logic          rx_ser, rx_fp, frame_vld;
  logic [FB-1:0] frame;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  int            rx_pos = FB - 1;
  logic          exp_ser = 1'b0, exp_fp = 1'b0;
  logic [FB-1:0] exp_frame = '0;
  bit            tx_q[$];

  always #10 clk = ~clk;

  t1_serial_framer i_t1_serial_framer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_en_i  (mode_en),
    .tx_bclk_i  (tx_bclk),
    .tx_data_i  (tx_data),
    .rx_bclk_i  (rx_bclk),
    .rx_data_i  (rx_data),
    .rx_fs_i    (rx_fs),
    .rx_ser_o   (rx_ser),
    .rx_fp_o    (rx_fp),
    .frame_o    (frame),
    .frame_vld_o(frame_vld)
  );

  task automatic chk(input string req, input logic [FB-1:0] act, input logic [FB-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one bit period = 8 system clocks on both paths
  task automatic step(input bit rb, input bit fs, input bit tb);
    int vld_seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      case (i)
        0: begin rx_data = rb; rx_fs = fs; rx_bclk = 1'b0; tx_bclk = 1'b1; end
        1: tx_data = tb;                  // after rising tx edge: R2
        2: rx_bclk = 1'b1;
        4: begin rx_data = ~rb; rx_fs = 1'b0; tx_bclk = 1'b0; end // R5 glitch
        default: ;
      endcase
      if (frame_vld) vld_seen++;
      if (!mode_en) begin
        chk("R8 rx_ser quiet", FB'(rx_ser), '0);
        chk("R8 rx_fp quiet", FB'(rx_fp), '0);
      end
    end
    // reference model
    if (mode_en) begin
      rx_pos  = fs ? 0 : ((rx_pos == FB - 1) ? 0 : rx_pos + 1);
      exp_ser = rb;
      exp_fp  = (rx_pos == 0);
      tx_q.push_back(tb);
      if (tx_q.size() == FB) begin
        foreach (tx_q[k]) exp_frame[FB-1-k] = tx_q[k];
        tx_q.delete();
        chk("R4 vld count at frame end", FB'(vld_seen), FB'(1));
      end else begin
        chk("R4 vld count mid frame", FB'(vld_seen), '0);
      end
    end else begin
      rx_pos  = FB - 1;
      exp_ser = 1'b0;
      exp_fp  = 1'b0;
      tx_q.delete();
      chk("R8 vld while disabled", FB'(vld_seen), '0);
    end
    chk("R5 R9 rx_ser", FB'(rx_ser), FB'(exp_ser));
    chk("R6 R7 rx_fp", FB'(rx_fp), FB'(exp_fp));
    chk("R2 R3 frame", frame, exp_frame);
  endtask

  function automatic bit pat(int k, int sel);
    case (sel)
      0:       return (k % 3) == 0;
      1:       return ((k * 7 + 3) % 5) < 2;
      2:       return 1'b1;
      default: return ((k / 4) % 2) == 1;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 rx_ser reset", FB'(rx_ser), '0);
    chk("R1 rx_fp reset", FB'(rx_fp), '0);
    chk("R1 vld reset", FB'(frame_vld), '0);
    chk("R1 frame reset", frame, '0);

    mode_en = 1'b1;
    for (int k = 0; k < FB; k++) step(pat(k, 1), k == 0, pat(k, 0));  // aligned frame
    for (int k = 0; k < FB; k++) step(pat(k, 0), 1'b0, pat(k, 1));    // R6 wrap
    for (int k = 0; k < 120; k++) step(pat(k, 3), k == 50, pat(k, 2)); // R7 realign
    for (int k = 0; k < 20; k++) step(pat(k, 1), 1'b0, pat(k, 3));
    mode_en = 1'b0;                                                     // R8 gap mid-frame
    for (int k = 0; k < 15; k++) step(pat(k, 0), k == 3, pat(k, 1));
    mode_en = 1'b1;
    for (int k = 0; k < FB + 10; k++) step(pat(k, 3), 1'b0, pat(k + 1, 1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule